// File: doc/BRIEF.md
# Event Descriptor Notification Controller

This block turns an incoming event trigger into a queue post and a notification decision. A trigger names a descriptor by block number and index and carries a 31-bit event data value. The controller reads the eight-word descriptor from a table through a request/acknowledge port. It then checks the descriptor's flags, and may hand the event data to an external queue-posting unit. When it does, it writes only the updated queue-state word back to the table. Last, it either forwards a notification (target block, target index, priority) as a one-cycle pulse or drops it.

Descriptor bits are described here with the least significant bit as bit 0. Word k of a table read arrives on `tbl_rdata[32*k +: 32]`. Word 0 carries valid (bit 31), enqueue (bit 30), unconditional notify (bit 29) and a queue size code (bits 19:16). Word 1 carries the queue generation bit (bit 22) and the queue write index (bits 21:0). Word 6 carries the format bit (bit 23), the target block (bits 22:19) and the target index (bits 18:0). Word 7 carries the priority (bits 23:16), which is used only with format 0.

Top module: `evd_notify_ctrl`

## Requirements
- R1: After reset, `trig_ready` is 1 and `tbl_req`, `post_req`, `ntf_valid`, `drop_err` and `unimpl_err` are 0.
- R2: A trigger is taken only while `trig_ready` is 1. `trig_ready` then stays 0 until the trigger is fully handled. The first table request is a read (`tbl_we`=0) with the trigger's block and index, held until `tbl_ack`.
- R3: If the read returns `tbl_err`=1, or word 0 bit 31 (valid) is 0, the controller pulses `drop_err` for one cycle. It makes no post, no table write and no notification.
- R4: If word 0 bit 30 (enqueue) is 1, the controller raises `post_req` until `post_ack`. `post_data` is {word 1 bit 22, event data} and `post_index` is word 1 bits 21:0. With enqueue 0 there is no post and no table write.
- R5: After `post_ack`, exactly one table write is made, with `tbl_we`=1 and `tbl_word`=1. `tbl_wdata` is word 1 with its index advanced by one and all bits above bit 22 unchanged.
- R6: The queue holds 2^(c+10) entries, where c is word 0 bits 19:16 and codes above 12 count as 12. When the advanced index reaches the entry count it becomes 0 and bit 22 of the written word inverts. Otherwise bit 22 is kept.
- R7: The notification carries `ntf_blk` = word 6 bits 22:19 and `ntf_idx` = word 6 bits 18:0.
- R8: With format 0 (word 6 bit 23 = 0), `ntf_prio` is word 7 bits 23:16. A priority of 0xFF, or any value above 7, masks the descriptor. A masked descriptor produces no notification and no error pulse.
- R9: With format 1, the priority field is ignored, the descriptor is never masked, and `ntf_prio` is 0.
- R10: For an unmasked descriptor whose word 0 bit 29 (unconditional notify) is 0, `unimpl_err` pulses for one cycle and no notification is made.
- R11: Masking is decided after posting. A masked descriptor with enqueue set still posts and writes word 1 back.
- R12: `ntf_valid`, `drop_err` and `unimpl_err` are one-cycle pulses, at most one of them per trigger, and never two at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger offered |
| trig_ready | output | 1 | Controller idle, trigger taken |
| trig_blk | input | 4 | Descriptor block number |
| trig_idx | input | 24 | Descriptor index |
| trig_data | input | 31 | Event data value |
| tbl_req | output | 1 | Table access request, held until ack |
| tbl_we | output | 1 | 1 = write one word, 0 = read all eight |
| tbl_word | output | 3 | Word number written |
| tbl_blk | output | 4 | Table access block number |
| tbl_idx | output | 24 | Table access index |
| tbl_wdata | output | 32 | Write data |
| tbl_ack | input | 1 | Table access done |
| tbl_err | input | 1 | Lookup failed (with ack) |
| tbl_rdata | input | 256 | Descriptor words, word k at bits 32k+31:32k |
| post_req | output | 1 | Queue append request, held until ack |
| post_index | output | 22 | Queue slot to write |
| post_data | output | 32 | Generation bit and event data |
| post_ack | input | 1 | Queue append done |
| ntf_valid | output | 1 | Notification pulse |
| ntf_blk | output | 4 | Target block |
| ntf_idx | output | 19 | Target index |
| ntf_prio | output | 8 | Notification priority |
| drop_err | output | 1 | Trigger dropped: lookup error or invalid descriptor |
| unimpl_err | output | 1 | Notification withheld: conditional-notify case |

## Verification
Directed triggers cover each outcome of the flag decoding. A failed lookup and a cleared valid bit both give a drop with no side effects. An enqueue with notify exercises the post payload, the word-1 write-back and the forwarded fields. A masked priority of 0xFF with enqueue shows that posting comes before masking, and a priority of 8 shows that out-of-range values mask too. Format 1 with a 0xFF priority field separates format handling from masking, and a cleared notify bit separates the unimplemented case from masking. Index wrap is tried at three queue size codes, one of them above the cap, to tell an index step apart from a wrap with a generation flip.

// File: rtl/evd_pkg.sv
package evd_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NWORDS    = 8;
  localparam int unsigned QSZ_W     = 4;
  localparam int unsigned TGT_BLK_W = 4;
  localparam int unsigned TGT_IDX_W = 19;
  localparam int unsigned PRIO_W    = 8;

  // bit positions, LSB = 0
  localparam int unsigned B_VALID   = 31;
  localparam int unsigned B_ENQ     = 30;
  localparam int unsigned B_UCOND   = 29;
  localparam int unsigned B_QSZ_LO  = 16;
  localparam int unsigned B_GEN     = 22;
  localparam int unsigned B_FMT     = 23;
  localparam int unsigned B_TBLK_LO = 19;
  localparam int unsigned B_PRIO_LO = 16;
  localparam int unsigned PRIO_TOP  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DROP, ST_POST, ST_WBACK, ST_DECIDE
  } ctl_state_e;

  typedef struct packed {
    logic                  valid;
    logic                  enq;
    logic                  ucond;
    logic [QSZ_W-1:0]      qsize;
    logic [WORD_W-1:0]     qword;
    logic                  fmt;
    logic [TGT_BLK_W-1:0]  tgt_blk;
    logic [TGT_IDX_W-1:0]  tgt_idx;
    logic [PRIO_W-1:0]     prio;
  } desc_fields_t;
endpackage

// File: rtl/evd_field_decode.sv
module evd_field_decode
  import evd_pkg::*;
#(
  parameter int unsigned NW = NWORDS,
  parameter int unsigned WW = WORD_W
) (
  input  logic [NW*WW-1:0] words,
  output desc_fields_t     fields
);
  logic [WW-1:0] w [NW];

  for (genvar k = 0; k < NW; k++) begin : g_split
    assign w[k] = words[k*WW +: WW];
  end

  logic unused_words;
  assign unused_words = ^words;

  always_comb begin
    fields         = '0;
    fields.valid   = w[0][B_VALID];
    fields.enq     = w[0][B_ENQ];
    fields.ucond   = w[0][B_UCOND];
    fields.qsize   = w[0][B_QSZ_LO +: QSZ_W];
    fields.qword   = w[1];
    fields.fmt     = w[6][B_FMT];
    fields.tgt_blk = w[6][B_TBLK_LO +: TGT_BLK_W];
    fields.tgt_idx = w[6][TGT_IDX_W-1:0];
    fields.prio    = w[7][B_PRIO_LO +: PRIO_W];
  end
endmodule

// File: rtl/evd_ring_advance.sv
module evd_ring_advance
  import evd_pkg::*;
#(
  parameter int unsigned QIDX_W   = 22,
  parameter int unsigned QSZ_BASE = 10,
  parameter int unsigned QSZ_CAP  = 12,
  parameter int unsigned GEN_BIT  = B_GEN
) (
  input  logic [WORD_W-1:0] w1_cur,
  input  logic [QSZ_W-1:0]  qsize,
  output logic [WORD_W-1:0] w1_next
);
  localparam logic [QIDX_W-1:0] ONE_I = QIDX_W'(1);
  localparam logic [QSZ_W-1:0]  CAP_C = QSZ_W'(QSZ_CAP);

  logic [QSZ_W-1:0]  qs_eff;
  logic [QIDX_W:0]   span;
  logic [QIDX_W-1:0] idx_mask;
  logic [QIDX_W-1:0] idx_inc;
  logic              wrapped;

  always_comb begin
    qs_eff   = (qsize > CAP_C) ? CAP_C : qsize;
    span     = (QIDX_W+1)'(1) << (int'(qs_eff) + QSZ_BASE);
    idx_mask = span[QIDX_W-1:0] - ONE_I;
    idx_inc  = (w1_cur[QIDX_W-1:0] + ONE_I) & idx_mask;
    wrapped  = (idx_inc == '0);
    w1_next              = w1_cur;
    w1_next[QIDX_W-1:0]  = idx_inc;
    w1_next[GEN_BIT]     = w1_cur[GEN_BIT] ^ wrapped;
  end
endmodule

// File: rtl/evd_ctrl_fsm.sv
module evd_ctrl_fsm
  import evd_pkg::*;
#(
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned IDX_W  = 24,
  parameter int unsigned QIDX_W = 22,
  localparam int unsigned EVD_W  = WORD_W - 1,
  localparam int unsigned WSEL_W = $clog2(NWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_valid,
  output logic                 trig_ready,
  input  logic [BLK_W-1:0]     trig_blk,
  input  logic [IDX_W-1:0]     trig_idx,
  input  logic [EVD_W-1:0]     trig_data,
  output logic                 tbl_req,
  output logic                 tbl_we,
  output logic [WSEL_W-1:0]    tbl_word,
  output logic [BLK_W-1:0]     tbl_blk,
  output logic [IDX_W-1:0]     tbl_idx,
  input  logic                 tbl_ack,
  input  logic                 tbl_err,
  input  desc_fields_t         dec,
  output logic                 post_req,
  output logic [QIDX_W-1:0]    post_index,
  output logic [WORD_W-1:0]    post_data,
  input  logic                 post_ack,
  output logic                 ntf_valid,
  output logic [TGT_BLK_W-1:0] ntf_blk,
  output logic [TGT_IDX_W-1:0] ntf_idx,
  output logic [PRIO_W-1:0]    ntf_prio,
  output logic                 drop_err,
  output logic                 unimpl_err,
  output logic [WORD_W-1:0]    held_w1,
  output logic [QSZ_W-1:0]     held_qsize
);
  localparam logic [PRIO_W-1:0] PRIO_LIM = PRIO_W'(PRIO_TOP);

  ctl_state_e        st_q, st_d;
  logic [BLK_W-1:0]  blk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [EVD_W-1:0]  data_q;
  desc_fields_t      desc_q;
  logic              trig_en, desc_en;
  logic              masked, fwd;

  assign trig_en = (st_q == ST_IDLE) && trig_valid;
  assign desc_en = (st_q == ST_FETCH) && tbl_ack;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (trig_valid) st_d = ST_FETCH;
      ST_FETCH:  if (tbl_ack) begin
                   if (tbl_err || !dec.valid) st_d = ST_DROP;
                   else if (dec.enq)          st_d = ST_POST;
                   else                       st_d = ST_DECIDE;
                 end
      ST_DROP:   st_d = ST_IDLE;
      ST_POST:   if (post_ack) st_d = ST_WBACK;
      ST_WBACK:  if (tbl_ack)  st_d = ST_DECIDE;
      ST_DECIDE: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (trig_en) begin
      blk_q  <= trig_blk;
      idx_q  <= trig_idx;
      data_q <= trig_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       desc_q <= '0;
    else if (desc_en) desc_q <= dec;
  end

  // decision
  always_comb begin
    masked = !desc_q.fmt && (desc_q.prio > PRIO_LIM);
    fwd    = !masked && desc_q.ucond;
  end

  always_comb begin
    trig_ready = (st_q == ST_IDLE);
    tbl_req    = (st_q == ST_FETCH) || (st_q == ST_WBACK);
    tbl_we     = (st_q == ST_WBACK);
    tbl_word   = (st_q == ST_WBACK) ? WSEL_W'(1) : '0;
    tbl_blk    = blk_q;
    tbl_idx    = idx_q;
    post_req   = (st_q == ST_POST);
    post_index = desc_q.qword[QIDX_W-1:0];
    post_data  = {desc_q.qword[B_GEN], data_q};
    drop_err   = (st_q == ST_DROP);
    ntf_valid  = (st_q == ST_DECIDE) && fwd;
    unimpl_err = (st_q == ST_DECIDE) && !masked && !desc_q.ucond;
    ntf_blk    = desc_q.tgt_blk;
    ntf_idx    = desc_q.tgt_idx;
    ntf_prio   = desc_q.fmt ? '0 : desc_q.prio;
    held_w1    = desc_q.qword;
    held_qsize = desc_q.qsize;
  end

  // R2: a new trigger is taken only when no access is outstanding
  a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ready |-> (!tbl_req && !post_req));
  // R2: table request held with stable address until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_req && !tbl_ack) |=> (tbl_req && $stable(tbl_idx) && $stable(tbl_blk)));
  // R4: post request held with stable payload until acknowledged
  a_r4_post_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (post_req && !post_ack) |=> (post_req && $stable(post_data) && $stable(post_index)));
  // R5: a table write starts only right after a post
  a_r5_write_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_we) |-> $past(post_req));
  // R8: forwarded priorities lie in the active range
  a_r8_prio_range: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (ntf_prio <= PRIO_LIM));
  // R12: outcome pulses are mutually exclusive
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ntf_valid, drop_err, unimpl_err}));
  // R12: outcome pulses last one cycle
  a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid || drop_err || unimpl_err) |=> trig_ready);
endmodule

// File: rtl/evd_notify_ctrl.sv
module evd_notify_ctrl
  import evd_pkg::*;
#(
  parameter int unsigned BLK_W    = 4,
  parameter int unsigned IDX_W    = 24,
  parameter int unsigned QIDX_W   = 22,
  parameter int unsigned QSZ_BASE = 10,
  parameter int unsigned QSZ_CAP  = 12,
  localparam int unsigned EVD_W  = WORD_W - 1,
  localparam int unsigned TBL_W  = NWORDS * WORD_W,
  localparam int unsigned WSEL_W = $clog2(NWORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_valid,
  output logic                 trig_ready,
  input  logic [BLK_W-1:0]     trig_blk,
  input  logic [IDX_W-1:0]     trig_idx,
  input  logic [EVD_W-1:0]     trig_data,
  output logic                 tbl_req,
  output logic                 tbl_we,
  output logic [WSEL_W-1:0]    tbl_word,
  output logic [BLK_W-1:0]     tbl_blk,
  output logic [IDX_W-1:0]     tbl_idx,
  output logic [WORD_W-1:0]    tbl_wdata,
  input  logic                 tbl_ack,
  input  logic                 tbl_err,
  input  logic [TBL_W-1:0]     tbl_rdata,
  output logic                 post_req,
  output logic [QIDX_W-1:0]    post_index,
  output logic [WORD_W-1:0]    post_data,
  input  logic                 post_ack,
  output logic                 ntf_valid,
  output logic [TGT_BLK_W-1:0] ntf_blk,
  output logic [TGT_IDX_W-1:0] ntf_idx,
  output logic [PRIO_W-1:0]    ntf_prio,
  output logic                 drop_err,
  output logic                 unimpl_err
);
  desc_fields_t      dec;
  logic [WORD_W-1:0] held_w1;
  logic [QSZ_W-1:0]  held_qsize;

  evd_field_decode #(.NW(NWORDS), .WW(WORD_W)) i_decode (
    .words  (tbl_rdata),
    .fields (dec)
  );

  evd_ctrl_fsm #(.BLK_W(BLK_W), .IDX_W(IDX_W), .QIDX_W(QIDX_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_ready (trig_ready),
    .trig_blk   (trig_blk),
    .trig_idx   (trig_idx),
    .trig_data  (trig_data),
    .tbl_req    (tbl_req),
    .tbl_we     (tbl_we),
    .tbl_word   (tbl_word),
    .tbl_blk    (tbl_blk),
    .tbl_idx    (tbl_idx),
    .tbl_ack    (tbl_ack),
    .tbl_err    (tbl_err),
    .dec        (dec),
    .post_req   (post_req),
    .post_index (post_index),
    .post_data  (post_data),
    .post_ack   (post_ack),
    .ntf_valid  (ntf_valid),
    .ntf_blk    (ntf_blk),
    .ntf_idx    (ntf_idx),
    .ntf_prio   (ntf_prio),
    .drop_err   (drop_err),
    .unimpl_err (unimpl_err),
    .held_w1    (held_w1),
    .held_qsize (held_qsize)
  );

  evd_ring_advance #(
    .QIDX_W(QIDX_W), .QSZ_BASE(QSZ_BASE), .QSZ_CAP(QSZ_CAP), .GEN_BIT(B_GEN)
  ) i_ring (
    .w1_cur  (held_w1),
    .qsize   (held_qsize),
    .w1_next (tbl_wdata)
  );

  // R6: a written word keeps every bit above the generation bit
  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_req && tbl_we) |-> (tbl_wdata[WORD_W-1:B_GEN+1] == held_w1[WORD_W-1:B_GEN+1]));
endmodule

// File: tb/test_evd_notify_ctrl.sv
module test_evd_notify_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic        trig_valid, trig_ready;
  logic [3:0]  trig_blk;
  logic [23:0] trig_idx;
  logic [30:0] trig_data;
  logic        tbl_req, tbl_we;
  logic [2:0]  tbl_word;
  logic [3:0]  tbl_blk;
  logic [23:0] tbl_idx;
  logic [31:0] tbl_wdata;
  logic        tbl_ack, tbl_err;
  logic [255:0] tbl_rdata;
  logic        post_req, post_ack;
  logic [21:0] post_index;
  logic [31:0] post_data;
  logic        ntf_valid, drop_err, unimpl_err;
  logic [3:0]  ntf_blk;
  logic [18:0] ntf_idx;
  logic [7:0]  ntf_prio;

  evd_notify_ctrl i_evd_notify_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_blk(trig_blk),
    .trig_idx(trig_idx), .trig_data(trig_data),
    .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_word(tbl_word), .tbl_blk(tbl_blk),
    .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata), .tbl_ack(tbl_ack), .tbl_err(tbl_err),
    .tbl_rdata(tbl_rdata),
    .post_req(post_req), .post_index(post_index), .post_data(post_data), .post_ack(post_ack),
    .ntf_valid(ntf_valid), .ntf_blk(ntf_blk), .ntf_idx(ntf_idx), .ntf_prio(ntf_prio),
    .drop_err(drop_err), .unimpl_err(unimpl_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [8][8];
  localparam logic [3:0] GOOD_BLK = 4'd2;

  int n_rd, n_wr, n_post, n_ntf, n_drop, n_unimpl;
  logic [3:0]  rd_blk;  logic [23:0] rd_idx;
  logic [2:0]  wr_word; logic [31:0] wr_data;
  logic [21:0] pst_idx; logic [31:0] pst_data;
  logic [3:0]  c_blk;   logic [18:0] c_idx;   logic [7:0] c_prio;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w0(bit v, bit e, bit u, logic [3:0] qs);
    logic [31:0] r = '0;
    r[31] = v; r[30] = e; r[29] = u; r[19:16] = qs; r[28] = 1'b1; r[26] = 1'b1;
    return r;
  endfunction
  function automatic logic [31:0] mk_w1(logic [8:0] hi, bit g, logic [21:0] ix);
    return {hi, g, ix};
  endfunction
  function automatic logic [31:0] mk_w6(bit f, logic [3:0] b, logic [18:0] ix);
    logic [31:0] r = 32'hAA00_0000;
    r[23] = f; r[22:19] = b; r[18:0] = ix;
    return r;
  endfunction
  function automatic logic [31:0] mk_w7(logic [7:0] p);
    return {8'h5C, p, 16'h3E1F};
  endfunction
  // expected write-back word from R5/R6
  function automatic logic [31:0] exp_w1(logic [31:0] w1, logic [3:0] qs);
    int c = (qs > 12) ? 12 : int'(qs);
    longint ent = longint'(1) << (c + 10);
    longint nx = (longint'(w1[21:0]) + 1) % ent;
    logic [31:0] r = w1;
    r[21:0] = nx[21:0];
    if (nx == 0) r[22] = ~w1[22];
    return r;
  endfunction

  task automatic set_desc(int k, logic [31:0] w0, logic [31:0] w1,
                          logic [31:0] w6, logic [31:0] w7);
    for (int j = 0; j < 8; j++) mem[k][j] = 32'h1111_0000 * j + 32'h0101;
    mem[k][0] = w0; mem[k][1] = w1; mem[k][6] = w6; mem[k][7] = w7;
  endtask

  // responders and monitor
  initial begin
    tbl_ack = 1'b0; tbl_err = 1'b0; tbl_rdata = '0; post_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (tbl_ack) tbl_ack = 1'b0;
      else if (tbl_req) begin
        tbl_ack = 1'b1;
        if (tbl_we) begin
          n_wr++; wr_word = tbl_word; wr_data = tbl_wdata;
        end else begin
          n_rd++; rd_blk = tbl_blk; rd_idx = tbl_idx;
          if (tbl_blk != GOOD_BLK || tbl_idx >= 24'd8) begin
            tbl_err = 1'b1; tbl_rdata = '1;
          end else begin
            tbl_err = 1'b0;
            for (int j = 0; j < 8; j++) tbl_rdata[32*j +: 32] = mem[tbl_idx[2:0]][j];
          end
        end
      end
      if (post_ack) post_ack = 1'b0;
      else if (post_req) begin
        post_ack = 1'b1; n_post++; pst_idx = post_index; pst_data = post_data;
      end
      if (ntf_valid) begin n_ntf++; c_blk = ntf_blk; c_idx = ntf_idx; c_prio = ntf_prio; end
      if (drop_err)   n_drop++;
      if (unimpl_err) n_unimpl++;
    end
  end

  task automatic fire(logic [3:0] b, logic [23:0] ix, logic [30:0] d);
    @(negedge clk);
    n_rd = 0; n_wr = 0; n_post = 0; n_ntf = 0; n_drop = 0; n_unimpl = 0;
    trig_valid = 1'b1; trig_blk = b; trig_idx = ix; trig_data = d;
    @(negedge clk);
    trig_valid = 1'b0;
    chk(trig_ready == 1'b0, "R2", "ready after accept", trig_ready, 0);
    for (int i = 0; i < 40 && !trig_ready; i++) @(negedge clk);
    chk(n_rd == 1 && rd_blk == b && rd_idx == ix, "R2", "read request idx",
        rd_idx, ix);
  endtask

  task automatic t_reset;
    chk(trig_ready && !tbl_req && !post_req && !ntf_valid && !drop_err && !unimpl_err,
        "R1", "reset outputs", {trig_ready, tbl_req, post_req, ntf_valid, drop_err, unimpl_err},
        6'b100000);
  endtask

  task automatic t_lookup_err;
    fire(4'd2, 24'd9, 31'h12);
    chk(n_drop == 1, "R3", "drop count (lookup error)", n_drop, 1);
    chk(n_post == 0 && n_wr == 0 && n_ntf == 0 && n_unimpl == 0, "R3", "side effects",
        n_post + n_wr + n_ntf + n_unimpl, 0);
  endtask

  task automatic t_invalid;
    set_desc(1, mk_w0(0, 1, 1, 0), mk_w1(0, 0, 3), mk_w6(0, 1, 5), mk_w7(2));
    fire(4'd2, 24'd1, 31'h55);
    chk(n_drop == 1, "R3", "drop count (invalid)", n_drop, 1);
    chk(n_post == 0 && n_wr == 0 && n_ntf == 0, "R3", "invalid side effects",
        n_post + n_wr + n_ntf, 0);
  endtask

  task automatic t_post_notify;
    logic [31:0] w1 = mk_w1(9'h1A5, 1'b1, 22'd5);
    set_desc(2, mk_w0(1, 1, 1, 0), w1, mk_w6(0, 4'hB, 19'h4_5A3C), mk_w7(8'd3));
    fire(4'd2, 24'd2, 31'h0123_4567);
    chk(n_post == 1 && pst_data == {1'b1, 31'h0123_4567}, "R4", "post data",
        pst_data, {1'b1, 31'h0123_4567});
    chk(pst_idx == 22'd5, "R4", "post index", pst_idx, 5);
    chk(n_wr == 1 && wr_word == 3'd1, "R5", "write-back word", wr_word, 1);
    chk(wr_data == exp_w1(w1, 4'd0), "R5", "write-back data", wr_data, exp_w1(w1, 4'd0));
    chk(n_ntf == 1 && c_blk == 4'hB && c_idx == 19'h4_5A3C, "R7", "target fields",
        {c_blk, c_idx}, {4'hB, 19'h4_5A3C});
    chk(c_prio == 8'd3 && n_drop == 0 && n_unimpl == 0, "R12", "single notify prio",
        c_prio, 3);
  endtask

  task automatic t_wrap(logic [3:0] qs, logic g, logic [21:0] ix, logic [21:0] exp_ix);
    logic [31:0] w1 = mk_w1(9'h0F0, g, ix);
    logic [31:0] ex;
    set_desc(3, mk_w0(1, 1, 1, qs), w1, mk_w6(0, 1, 1), mk_w7(0));
    fire(4'd2, 24'd3, 31'h7);
    ex = exp_w1(w1, qs);
    chk(ex[21:0] == exp_ix, "R6", "model index", ex[21:0], exp_ix);
    chk(n_wr == 1 && wr_data == ex, "R6", "wrap write-back", wr_data, ex);
  endtask

  task automatic t_masked_enq;
    logic [31:0] w1 = mk_w1(9'h003, 1'b0, 22'd77);
    set_desc(4, mk_w0(1, 1, 1, 1), w1, mk_w6(0, 2, 9), mk_w7(8'hFF));
    fire(4'd2, 24'd4, 31'h4000_0001);
    chk(n_post == 1 && n_wr == 1 && wr_data == exp_w1(w1, 4'd1), "R11",
        "masked still posts", wr_data, exp_w1(w1, 4'd1));
    chk(n_ntf == 0 && n_unimpl == 0 && n_drop == 0, "R8", "masked 0xFF silent",
        n_ntf + n_unimpl + n_drop, 0);
  endtask

  task automatic t_prio_high;
    set_desc(5, mk_w0(1, 0, 1, 0), mk_w1(0, 0, 0), mk_w6(0, 2, 9), mk_w7(8'd8));
    fire(4'd2, 24'd5, 31'h1);
    chk(n_ntf == 0 && n_unimpl == 0, "R8", "priority 8 masked", n_ntf + n_unimpl, 0);
    chk(n_post == 0 && n_wr == 0, "R4", "no enqueue no post", n_post + n_wr, 0);
  endtask

  task automatic t_format1;
    set_desc(6, mk_w0(1, 0, 1, 0), mk_w1(0, 0, 0), mk_w6(1, 4'h7, 19'h7_FFFF), mk_w7(8'hFF));
    fire(4'd2, 24'd6, 31'h2);
    chk(n_ntf == 1 && c_prio == 8'd0, "R9", "format 1 forwards prio 0", c_prio, 0);
    chk(c_blk == 4'h7 && c_idx == 19'h7_FFFF, "R7", "format 1 target", {c_blk, c_idx},
        {4'h7, 19'h7_FFFF});
  endtask

  task automatic t_no_ucond;
    set_desc(7, mk_w0(1, 0, 0, 0), mk_w1(0, 0, 0), mk_w6(0, 3, 3), mk_w7(8'd2));
    fire(4'd2, 24'd7, 31'h3);
    chk(n_unimpl == 1 && n_ntf == 0, "R10", "conditional notify withheld",
        n_unimpl, 1);
    chk(n_drop == 0, "R12", "only one outcome", n_drop, 0);
  endtask

  initial begin
    trig_valid = 1'b0; trig_blk = '0; trig_idx = '0; trig_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lookup_err();
    t_invalid();
    t_post_notify();
    t_wrap(4'd0, 1'b0, 22'd1023, 22'd0);
    t_wrap(4'd2, 1'b1, 22'd4095, 22'd0);
    t_wrap(4'd2, 1'b1, 22'd4094, 22'd4095);
    t_wrap(4'd15, 1'b0, 22'h3F_FFFF, 22'd0);
    t_masked_enq();
    t_prio_high();
    t_format1();
    t_no_ucond();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule